// File: doc/BRIEF.md
# Pixel Copy Read Cache Controller

This block is the read half of a graphics pixel writer. It pops pixel commands from a command FIFO through a ready/shift handshake. A copy command asks for one pixel held in a 16-bit memory word. The block keeps a single-entry cache of the last word it fetched. When the requested word address matches the cache and the cache is valid, the copied colour comes out in the same cycle and no memory request is made. When the address does not match, the block raises a one-clock read request on memory port A, in the same cycle as the command, and stops popping the FIFO. When the port A data-ready strobe arrives, it captures the returned word and delivers the copied colour straight from the incoming data.

The copied colour is formed from the pixel depth, the pixel index inside the word and a base colour, all carried by the command. Port B belongs to the write path. Only its wait and ready signals reach this block, and they take part in the FIFO stall. Two saturating 8-bit collision counters, one for reads and one for writes, sit beside the cache. A timeout drops a read that is never answered and raises a sticky error flag.

The control is a two-state machine. In IDLE no read is outstanding. In WAIT_A a port A read is outstanding. There are four transitions:
- IDLE to WAIT_A on a copy miss.
- WAIT_A to IDLE on the data-ready strobe or on timeout expiry.
- WAIT_A to WAIT_A on a copy miss accepted in the strobe cycle.
- Any state to IDLE on reset.

Top module: `pxcopy_rd_cache`

## Requirements
- R1: A copy command (code 4'h3) hits when the cache is valid and its address equals the cached address. A hit makes no request, and `copy_colour_vld` is high in the same cycle, with the colour taken from the cached word and the command's own depth, index and base.
- R2: `rd_req_a` is high only in the cycle a copy command is popped and misses, never during reset, and it lasts one clock per missing command.
- R3: On a miss the block records the new address, marks the cache invalid and enters WAIT_A. While in WAIT_A with `rd_ack_a` low, `cmd_shift` stays low.
- R4: A `rd_ack_a` strobe in WAIT_A makes the cache valid with `rd_data_a`. In that cycle `copy_colour_vld` is high, with the colour computed from `rd_data_a` and the parameters latched with the missing command, and `cmd_shift` may already be high.
- R5: The depth, index and base are latched on every copy command, hit or miss. Successive hits on one word may use different parameters.
- R6: `cmd_shift` = `cmd_ready` & !rst & !(WAIT_A & !`rd_ack_a`) & !(`wr_wait_b` & !`rd_ack_b`).
- R7: Depth codes 0,1,2,3,4 mean 1,2,4,8,16 bits per pixel. Pixel index 0 sits at the most significant end, and only the low log2(16/width) bits of the index are used. The colour is the base with its low width bits replaced by the pixel. At 16 bpp the colour is the whole word. Depth codes 5 to 7 give 0.
- R8: A non-copy command is popped with no request, no stall and no colour strobe.
- R9: A `rd_ack_a` strobe in IDLE is ignored: a later copy to the cached address still hits and returns the old word's pixel.
- R10: If no `rd_ack_a` arrives within TIMEOUT_CYC clocks after the request, the block returns to IDLE with the cache invalid and sets `timeout_err` until reset. An ack in clock TIMEOUT_CYC itself is still accepted.
- R11: Each collision counter increments on its inc input, saturates at 255, and clears on its clr input, which wins over inc.
- R12: Synchronous reset wins over everything. It clears the state, the cache valid flag, the counters and `timeout_err`, and holds `cmd_shift` low.
- R13: A copy popped in the strobe cycle is judged against the cache as it stood before the strobe, so it misses and issues its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_ready | input | 1 | FIFO has a command on its outputs |
| cmd_code | input | 4 | Command code; 4'h3 is copy |
| cmd_addr | input | ADDR_W | Memory word address of the pixel |
| cmd_base | input | 16 | Base colour |
| cmd_bpp | input | 3 | Pixel depth code |
| cmd_pos | input | 4 | Pixel index inside the word |
| cmd_shift | output | 1 | Pop the FIFO this cycle |
| rd_req_a | output | 1 | Port A read request pulse |
| rd_ack_a | input | 1 | Port A data-ready strobe |
| rd_data_a | input | 16 | Port A read data |
| wr_wait_b | input | 1 | Write path waiting on port B |
| rd_ack_b | input | 1 | Port B data-ready strobe |
| copy_colour | output | 16 | Copied pixel colour |
| copy_colour_vld | output | 1 | `copy_colour` is valid this cycle |
| rd_coll_inc | input | 1 | Read collision event |
| rd_coll_clr | input | 1 | Clear read collision counter |
| wr_coll_inc | input | 1 | Write collision event |
| wr_coll_clr | input | 1 | Clear write collision counter |
| rd_coll_cnt | output | 8 | Read collision count |
| wr_coll_cnt | output | 8 | Write collision count |
| timeout_err | output | 1 | Sticky read timeout flag |

## Verification
The bench targets four corner cases:
- A strobe cycle that also pops a new copy. A design that released the FIFO only after the wait flag cleared would lose a cycle. A design that treated that copy as a hit would skip its request.
- Two hits on one word with different depth and index. A design that kept the parameters only on a miss would return the stale pixel.
- A stray strobe in IDLE. A design that accepted it would overwrite the cached word.
- A read that is never answered. A design without a timeout would hang with `cmd_shift` low for good.

Port B stalls and counter saturation with clear-over-increment are checked alongside.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    localparam int PIX_W = 16;
    localparam int BPP_W = 3;
    localparam int POS_W = 4;
    localparam int CMD_W = 4;
    localparam int CNT_W = 8;

    localparam logic [CMD_W-1:0] CMD_NOP  = 4'h0;
    localparam logic [CMD_W-1:0] CMD_COPY = 4'h3;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_WAIT_A = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic [PIX_W-1:0] base;
        logic [BPP_W-1:0] bpp;
        logic [POS_W-1:0] pos;
    } pix_param_t;
endpackage

// File: rtl/pxc_colour_extract.sv
module pxc_colour_extract
    import pxc_pkg::*;
(
    input  logic [PIX_W-1:0] word,
    input  pix_param_t       prm,
    output logic [PIX_W-1:0] colour
);
    always_comb begin
        colour = '0;
        case (prm.bpp)
            3'd0: colour = {prm.base[15:1], word[4'd15 - prm.pos]};
            3'd1: colour = {prm.base[15:2], word[(4'd14 - {prm.pos[2:0], 1'b0}) +: 2]};
            3'd2: colour = {prm.base[15:4], word[(4'd12 - {prm.pos[1:0], 2'b00}) +: 4]};
            3'd3: colour = {prm.base[15:8], (prm.pos[0] ? word[7:0] : word[15:8])};
            3'd4: colour = word;
            default: colour = '0;
        endcase
    end
endmodule

// File: rtl/pxc_sat_counter.sv
module pxc_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pxcopy_rd_cache.sv
module pxcopy_rd_cache
    import pxc_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int TIMEOUT_CYC = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_ready,
    input  logic [3:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [15:0]       cmd_base,
    input  logic [2:0]        cmd_bpp,
    input  logic [3:0]        cmd_pos,
    output logic              cmd_shift,
    output logic              rd_req_a,
    input  logic              rd_ack_a,
    input  logic [15:0]       rd_data_a,
    input  logic              wr_wait_b,
    input  logic              rd_ack_b,
    output logic [15:0]       copy_colour,
    output logic              copy_colour_vld,
    input  logic              rd_coll_inc,
    input  logic              rd_coll_clr,
    input  logic              wr_coll_inc,
    input  logic              wr_coll_clr,
    output logic [7:0]        rd_coll_cnt,
    output logic [7:0]        wr_coll_cnt,
    output logic              timeout_err
);
    localparam int TMR_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

    rd_state_e         state_q, state_d;
    logic [ADDR_W-1:0] cache_addr;
    logic [PIX_W-1:0]  cache_word;
    logic              cache_vld;
    pix_param_t        prm_q, prm_cmd, prm_sel;
    logic [TMR_W-1:0]  tmr_q;
    logic              err_q;

    logic wait_a, a_arrive, tmr_expire, is_copy, hit, miss;
    logic [PIX_W-1:0] word_sel;

    assign prm_cmd = '{base: cmd_base, bpp: cmd_bpp, pos: cmd_pos};

    // Output and decode process
    always_comb begin
        wait_a     = (state_q == ST_WAIT_A);
        a_arrive   = wait_a && rd_ack_a && !rst;
        tmr_expire = wait_a && !rd_ack_a && (tmr_q == TMR_LAST);
        cmd_shift  = cmd_ready && !rst
                     && !(wait_a && !rd_ack_a)
                     && !(wr_wait_b && !rd_ack_b);
        is_copy    = cmd_shift && (cmd_code == CMD_COPY);
        hit        = cache_vld && (cmd_addr == cache_addr);
        miss       = is_copy && !hit;
        rd_req_a   = miss && !rst;
        copy_colour_vld = a_arrive || (is_copy && hit);
        word_sel   = a_arrive ? rd_data_a : cache_word;
        prm_sel    = a_arrive ? prm_q     : prm_cmd;
        timeout_err = err_q;
    end

    pxc_colour_extract u_extract (
        .word   (word_sel),
        .prm    (prm_sel),
        .colour (copy_colour)
    );

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (miss) state_d = ST_WAIT_A;
            end
            ST_WAIT_A: begin
                if (miss)                        state_d = ST_WAIT_A;
                else if (a_arrive || tmr_expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cache_addr <= '0;
            cache_word <= '0;
            cache_vld  <= 1'b0;
            prm_q      <= '0;
            tmr_q      <= '0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (a_arrive) begin
                cache_vld  <= 1'b1;
                cache_word <= rd_data_a;
            end
            if (is_copy) prm_q <= prm_cmd;
            if (miss) begin
                cache_addr <= cmd_addr;
                cache_vld  <= 1'b0;
                tmr_q      <= '0;
            end else if (wait_a && !a_arrive) begin
                tmr_q <= tmr_q + 1'b1;
            end
            if (tmr_expire) err_q <= 1'b1;
        end
    end

    pxc_sat_counter #(.W(CNT_W)) u_rd_coll (
        .clk(clk), .rst(rst), .clr(rd_coll_clr), .inc(rd_coll_inc), .count(rd_coll_cnt)
    );
    pxc_sat_counter #(.W(CNT_W)) u_wr_coll (
        .clk(clk), .rst(rst), .clr(wr_coll_clr), .inc(wr_coll_inc), .count(wr_coll_cnt)
    );
endmodule

// File: rtl/pxcopy_rd_cache_chk.sv
module pxcopy_rd_cache_chk
    import pxc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_shift,
    input logic              rd_req_a,
    input logic              rd_ack_a,
    input logic              copy_colour_vld,
    input logic              rd_coll_clr,
    input logic [7:0]        rd_coll_cnt,
    input logic [7:0]        wr_coll_cnt,
    input logic              timeout_err,
    input logic              wait_a,
    input logic              cache_vld,
    input logic [ADDR_W-1:0] cache_addr
);
    // R2
    req_is_copy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_a |-> (cmd_shift && cmd_code == CMD_COPY));

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_a |=> (!rd_req_a || rd_ack_a));

    // R1
    req_not_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_a |-> !(cache_vld && cmd_addr == cache_addr));

    // R3
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_a && !rd_ack_a) |-> !cmd_shift);

    // R4
    arrive_vld_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_a && rd_ack_a) |-> copy_colour_vld);

    // R11
    rd_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_coll_cnt == 8'hFF && !rd_coll_clr) |=> (rd_coll_cnt == 8'hFF));

    // R10
    err_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> $past(wait_a));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_coll_cnt == 8'h00 && wr_coll_cnt == 8'h00 && !timeout_err && !wait_a));
endmodule

bind pxcopy_rd_cache pxcopy_rd_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_shift(cmd_shift), .rd_req_a(rd_req_a), .rd_ack_a(rd_ack_a),
    .copy_colour_vld(copy_colour_vld), .rd_coll_clr(rd_coll_clr),
    .rd_coll_cnt(rd_coll_cnt), .wr_coll_cnt(wr_coll_cnt),
    .timeout_err(timeout_err), .wait_a(wait_a), .cache_vld(cache_vld),
    .cache_addr(cache_addr)
);

// File: tb/test_pxcopy_rd_cache.sv
module test_pxcopy_rd_cache;
    localparam int TO = 255;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, cmd_ready, rd_ack_a, wr_wait_b, rd_ack_b;
    logic [3:0]  cmd_code, cmd_pos;
    logic [19:0] cmd_addr;
    logic [15:0] cmd_base, rd_data_a;
    logic [2:0]  cmd_bpp;
    logic        rd_coll_inc, rd_coll_clr, wr_coll_inc, wr_coll_clr;
    logic        cmd_shift, rd_req_a, copy_colour_vld, timeout_err;
    logic [15:0] copy_colour;
    logic [7:0]  rd_coll_cnt, wr_coll_cnt;

    pxcopy_rd_cache i_pxcopy_rd_cache (
        .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_base(cmd_base), .cmd_bpp(cmd_bpp), .cmd_pos(cmd_pos),
        .cmd_shift(cmd_shift), .rd_req_a(rd_req_a), .rd_ack_a(rd_ack_a),
        .rd_data_a(rd_data_a), .wr_wait_b(wr_wait_b), .rd_ack_b(rd_ack_b),
        .copy_colour(copy_colour), .copy_colour_vld(copy_colour_vld),
        .rd_coll_inc(rd_coll_inc), .rd_coll_clr(rd_coll_clr),
        .wr_coll_inc(wr_coll_inc), .wr_coll_clr(wr_coll_clr),
        .rd_coll_cnt(rd_coll_cnt), .wr_coll_cnt(wr_coll_cnt),
        .timeout_err(timeout_err)
    );

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R12";

    // reference model state
    bit          m_vld, m_wait, m_err;
    logic [19:0] m_addr;
    logic [15:0] m_word, m_base;
    logic [2:0]  m_bpp;
    logic [3:0]  m_pos;
    int          m_tmr, m_rc, m_wc;

    function automatic logic [15:0] ref_colour(logic [15:0] word, logic [15:0] base,
                                               int bpp, int pos);
        int w, n, idx, sh, mask;
        if (bpp == 4) return word;
        if (bpp > 4) return 16'h0;
        w = 1 << bpp; n = 16 / w; idx = pos % n;
        sh = 16 - w * (idx + 1); mask = (1 << w) - 1;
        return 16'((int'(base) & ~mask) | ((int'(word) >> sh) & mask));
    endfunction

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit arr, e_shift, e_copy, e_hit, e_req, e_vld;
        logic [15:0] e_col;
        #1;
        arr     = m_wait && rd_ack_a && !rst;
        e_shift = cmd_ready && !rst && !(m_wait && !rd_ack_a) && !(wr_wait_b && !rd_ack_b);
        e_copy  = e_shift && cmd_code == 4'h3;
        e_hit   = m_vld && cmd_addr == m_addr;
        e_req   = e_copy && !e_hit;
        e_vld   = arr || (e_copy && e_hit);
        e_col   = arr ? ref_colour(rd_data_a, m_base, m_bpp, m_pos)
                      : ref_colour(m_word, cmd_base, cmd_bpp, cmd_pos);
        chk("cmd_shift", cmd_shift, e_shift);
        chk("rd_req_a", rd_req_a, e_req);
        chk("copy_colour_vld", copy_colour_vld, e_vld);
        if (e_vld) chk("copy_colour", copy_colour, e_col);
        chk("timeout_err", timeout_err, m_err);
        chk("rd_coll_cnt", rd_coll_cnt, m_rc);
        chk("wr_coll_cnt", wr_coll_cnt, m_wc);
        @(posedge clk);
        if (rst) begin
            m_vld = 0; m_wait = 0; m_err = 0; m_tmr = 0; m_rc = 0; m_wc = 0;
        end else begin
            if (m_wait) begin
                if (rd_ack_a) begin m_vld = 1; m_word = rd_data_a; m_wait = 0; end
                else if (m_tmr == TO - 1) begin m_wait = 0; m_err = 1; end
                else m_tmr++;
            end
            if (e_copy) begin
                m_base = cmd_base; m_bpp = cmd_bpp; m_pos = cmd_pos;
                if (!e_hit) begin m_addr = cmd_addr; m_vld = 0; m_wait = 1; m_tmr = 0; end
            end
            if (rd_coll_clr) m_rc = 0; else if (rd_coll_inc && m_rc < 255) m_rc++;
            if (wr_coll_clr) m_wc = 0; else if (wr_coll_inc && m_wc < 255) m_wc++;
        end
        @(negedge clk);
    endtask

    task automatic cmd(logic [3:0] code, logic [19:0] a, logic [15:0] b, logic [2:0] bp, logic [3:0] p);
        cmd_ready = 1; cmd_code = code; cmd_addr = a; cmd_base = b; cmd_bpp = bp; cmd_pos = p;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; cmd_ready = 1; cmd_code = 4'h3; cmd_addr = 20'h10; cmd_base = 0;
        cmd_bpp = 0; cmd_pos = 0; rd_ack_a = 0; rd_data_a = 0; wr_wait_b = 0; rd_ack_b = 0;
        rd_coll_inc = 1; rd_coll_clr = 0; wr_coll_inc = 1; wr_coll_clr = 0;
        m_addr = 0; m_word = 0; m_base = 0; m_bpp = 0; m_pos = 0;
        m_vld = 0; m_wait = 0; m_err = 0; m_tmr = 0; m_rc = 0; m_wc = 0;
        @(negedge clk);
        tag = "R12";
        for (int i = 0; i < 3; i++) tick();
        rst = 0; rd_coll_inc = 0; wr_coll_inc = 0;

        tag = "R8";  cmd(4'h0, 20'h10, 16'h0, 3'd0, 4'd0); tick(); tick();
        tag = "R2";  cmd(4'h3, 20'h10, 16'h1200, 3'd3, 4'd1); tick();
        tag = "R3";  cmd(4'h0, 20'h0, 16'h0, 3'd0, 4'd0);
        for (int i = 0; i < 3; i++) tick();
        tag = "R4";  rd_ack_a = 1; rd_data_a = 16'hA5C3; cmd_ready = 0; tick();
        rd_ack_a = 0; rd_data_a = 16'h0;
        tag = "R1";  cmd(4'h3, 20'h10, 16'hFFFF, 3'd0, 4'd5); tick();
        tag = "R5";  cmd(4'h3, 20'h10, 16'h0000, 3'd1, 4'd6); tick();
        tag = "R7";  cmd(4'h3, 20'h10, 16'h8880, 3'd2, 4'd7); tick();
        cmd(4'h3, 20'h10, 16'h5555, 3'd3, 4'd0); tick();
        cmd(4'h3, 20'h10, 16'h1111, 3'd4, 4'd3); tick();
        cmd(4'h3, 20'h10, 16'h1111, 3'd6, 4'd3); tick();
        cmd(4'h3, 20'h10, 16'hABCD, 3'd0, 4'd15); tick();
        tag = "R9";  cmd_ready = 0; rd_ack_a = 1; rd_data_a = 16'h0F0F; tick();
        rd_ack_a = 0; cmd(4'h3, 20'h10, 16'h0, 3'd4, 4'd0); tick();
        tag = "R13"; cmd(4'h3, 20'h20, 16'h0, 3'd2, 4'd2); tick();
        cmd_ready = 0; tick();
        rd_ack_a = 1; rd_data_a = 16'h1234; cmd(4'h3, 20'h20, 16'hF000, 3'd1, 4'd1); tick();
        rd_ack_a = 0; cmd_ready = 0; tick();
        rd_ack_a = 1; rd_data_a = 16'h4321; tick();
        rd_ack_a = 0; cmd(4'h3, 20'h20, 16'h0, 3'd3, 4'd1); tick();
        tag = "R6";  wr_wait_b = 1; cmd(4'h0, 20'h0, 16'h0, 3'd0, 4'd0); tick(); tick();
        rd_ack_b = 1; tick();
        wr_wait_b = 0; rd_ack_b = 0; tick();
        tag = "R10"; cmd(4'h3, 20'h30, 16'h0, 3'd4, 4'd0); tick();
        cmd(4'h0, 20'h0, 16'h0, 3'd0, 4'd0);
        for (int i = 0; i < TO + 5; i++) tick();
        cmd(4'h3, 20'h30, 16'h0, 3'd4, 4'd0); tick();
        cmd_ready = 0;
        for (int i = 0; i < TO - 1; i++) tick();
        rd_ack_a = 1; rd_data_a = 16'hBEEF; tick();
        rd_ack_a = 0; tick();
        tag = "R11"; rd_coll_inc = 1; wr_coll_inc = 1;
        for (int i = 0; i < 260; i++) tick();
        rd_coll_clr = 1; tick();
        rd_coll_clr = 0; tick(); tick();
        wr_coll_clr = 1; tick();
        wr_coll_clr = 0; rd_coll_inc = 0; wr_coll_inc = 0; tick();
        tag = "R12"; cmd(4'h3, 20'h40, 16'h0, 3'd4, 4'd0); tick();
        rst = 1; tick();
        rst = 0; cmd_ready = 0; tick();
        cmd(4'h3, 20'h30, 16'h0, 3'd4, 4'd0); tick();
        cmd_ready = 0; tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule